// File: doc/BRIEF.md
# Lookup-Coded Clock-Enable Divider Bank

This block turns one fast source clock into a set of clock-enable strobes, one per output. Each output carries a 4-bit code that picks its divide ratio from a fixed table of fourteen ratios. The ratios are not evenly spaced and include odd and non-power-of-two values. Two code points are reserved. Each output also has its own mask of codes it may legally take.

Software writes codes into shadow registers through a 32-bit word write port. Four codes are packed into each word. A code that is reserved, or that is outside that output's mask, is refused and sets a sticky error flag for that output. The shadow codes have no effect on the strobes until software sets the commit bit. On the next clock, every output loads its shadow code into its active register at the same moment, and all divide counters restart together. The commit bit then clears itself, so software can poll for completion.

The control sequence is a two-state machine. `IDLE` waits for a commit request. The transition `IDLE -> APPLY` is taken when a write to word 0 has bit 31 set. `APPLY` lasts exactly one cycle, copies shadow to active and restarts the counters. Its only transition is the unconditional `APPLY -> IDLE`.

Top module: `dvb_bank`

## Requirements
- R1: Code to divisor mapping: 0:2, 1:3, 2:4, 3:6, 4:8, 5:12, 6:16, 7:18, 8:24, 9:32, 10:36, 11:48, 13:72, 14:96.
- R2: Codes 12 and 15 are reserved. A write carrying one is ignored for that output and sets that output's error flag.
- R3: Each output i has a 16-bit legal-code mask (bit c set means code c is allowed). By default outputs 0 to 4 use 0x6FFF and output 5 uses 0x677C. A masked-out code leaves the shadow code unchanged and sets err_o[i].
- R4: A legal code write changes only the shadow code. The tick_o strobes keep their current period until a commit.
- R5: A write to word 0 with bit 31 set requests a commit. On the following clock edge all active codes take the shadow values and all counters restart at zero, so each output's first tick appears N cycles after that edge.
- R6: The commit bit reads as 1 in word 0, bit 31, for exactly the one cycle between the request and the apply edge, and reads 0 otherwise. A commit request made while the bit reads 1 is ignored.
- R7: Each output raises tick_o for exactly one source cycle in every N cycles, where N is its active divisor. This holds for odd N as well.
- R8: After reset all shadow and active codes are 0 (divide by 2), all error flags are 0 and the commit bit is 0.
- R9: Output i's shadow code reads back in word i/4 at bits 4*(i%4)+3 to 4*(i%4). A write to a word updates every output field in that word. Bits without a field read 0.
- R10: Error flags are sticky. Once set, they stay set until reset, whatever is written afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Word write strobe |
| wr_addr | input | ADDR_W | Word index for the write |
| wr_data | input | 32 | Packed codes; bit 31 of word 0 requests a commit |
| rd_addr | input | ADDR_W | Word index for the read |
| rd_data | output | 32 | Shadow codes of the addressed word, plus the commit bit in word 0 |
| tick_o | output | NUM_OUT | One-cycle enable strobe per output |
| err_o | output | NUM_OUT | Sticky refused-code flag per output |

## Verification
The assertions assume that reset is applied before the first checked edge. They also assume that every active code came through the legal-code filter, so no divisor is ever below 2. The bench only feeds codes through the write port, including deliberately illegal ones, so that assumption always holds. The bench asserts reset only at the start. It changes inputs just after the rising edge, so a write and a commit request never land on the same edge as a sample. A commit request is never issued while a previous one is still pending.

// File: rtl/dvb_pkg.sv
package dvb_pkg;
    localparam int CODE_W = 4;
    localparam int CNT_W  = 7;
    localparam int SLOTS  = 4;
    localparam int KICK_BIT = 31;

    function automatic logic [CNT_W-1:0] code_to_div(input logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] d;
        unique case (code)
            4'd0:  d = 7'd2;
            4'd1:  d = 7'd3;
            4'd2:  d = 7'd4;
            4'd3:  d = 7'd6;
            4'd4:  d = 7'd8;
            4'd5:  d = 7'd12;
            4'd6:  d = 7'd16;
            4'd7:  d = 7'd18;
            4'd8:  d = 7'd24;
            4'd9:  d = 7'd32;
            4'd10: d = 7'd36;
            4'd11: d = 7'd48;
            4'd13: d = 7'd72;
            4'd14: d = 7'd96;
            default: d = 7'd0;
        endcase
        return d;
    endfunction

    function automatic logic code_ok(input logic [CODE_W-1:0] code, input logic [15:0] mask);
        return mask[code] && (code_to_div(code) != '0);
    endfunction

    typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_APPLY = 1'b1} kick_state_t;
endpackage

// File: rtl/dvb_kick_ctl.sv
module dvb_kick_ctl
    import dvb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic kick_req,
    output logic commit
);
    kick_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (kick_req) state_nx = ST_APPLY;
            ST_APPLY: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_APPLY: commit = 1'b1;
            default:  commit = 1'b0;
        endcase
    end
endmodule

// File: rtl/dvb_regs.sv
module dvb_regs
    import dvb_pkg::*;
#(
    parameter int NUM_OUT   = 6,
    parameter int NUM_WORDS = 2,
    parameter int ADDR_W    = 1,
    parameter logic [NUM_OUT*16-1:0] MASKS = '1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [31:0]               wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    input  logic                      busy,
    output logic [31:0]               rd_data,
    output logic                      kick_req,
    output logic [NUM_OUT*CODE_W-1:0] shd_codes,
    output logic [NUM_OUT-1:0]        err
);
    logic unused_hi;
    assign unused_hi = ^wr_data[30:SLOTS*CODE_W];

    assign kick_req = wr_en && (wr_addr == '0) && wr_data[KICK_BIT] && !busy;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_field
        localparam int WORD = i / SLOTS;
        localparam int SLOT = i % SLOTS;
        localparam logic [15:0] MASK = MASKS[16*i +: 16];
        logic [CODE_W-1:0] wcode;
        logic              hit;
        assign wcode = wr_data[CODE_W*SLOT +: CODE_W];
        assign hit   = wr_en && (wr_addr == ADDR_W'(WORD));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shd_codes[CODE_W*i +: CODE_W] <= '0;
                err[i] <= 1'b0;
            end else if (hit) begin
                if (code_ok(wcode, MASK)) shd_codes[CODE_W*i +: CODE_W] <= wcode;
                else                      err[i] <= 1'b1;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_OUT; i++) begin
            if (rd_addr == ADDR_W'(i / SLOTS))
                rd_data[CODE_W*(i % SLOTS) +: CODE_W] = shd_codes[CODE_W*i +: CODE_W];
        end
        if (rd_addr == '0) rd_data[KICK_BIT] = busy;
    end
endmodule

// File: rtl/dvb_div_cell.sv
module dvb_div_cell
    import dvb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [CODE_W-1:0] new_code,
    output logic [CODE_W-1:0] act_code,
    output logic              tick
);
    logic [CNT_W-1:0] cnt, lim;

    assign lim  = code_to_div(act_code) - 7'd1;
    assign tick = (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_code <= '0;
            cnt      <= '0;
        end else if (commit) begin
            act_code <= new_code;
            cnt      <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 7'd1;
        end
    end
endmodule

// File: rtl/dvb_bank.sv
module dvb_bank
    import dvb_pkg::*;
#(
    parameter int NUM_OUT = 6,
    parameter logic [NUM_OUT*16-1:0] OUT_MASKS = {16'h677C, {5{16'h6FFF}}},
    localparam int NUM_WORDS = (NUM_OUT + SLOTS - 1) / SLOTS,
    localparam int ADDR_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [31:0]        rd_data,
    output logic [NUM_OUT-1:0] tick_o,
    output logic [NUM_OUT-1:0] err_o
);
    logic                      kick_req, commit;
    logic [NUM_OUT*CODE_W-1:0] shd_codes, act_codes;

    dvb_kick_ctl u_kick (
        .clk(clk), .rst_n(rst_n), .kick_req(kick_req), .commit(commit)
    );

    dvb_regs #(
        .NUM_OUT(NUM_OUT), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .MASKS(OUT_MASKS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .busy(commit), .rd_data(rd_data), .kick_req(kick_req),
        .shd_codes(shd_codes), .err(err_o)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_div
        dvb_div_cell u_cell (
            .clk(clk), .rst_n(rst_n), .commit(commit),
            .new_code(shd_codes[CODE_W*i +: CODE_W]),
            .act_code(act_codes[CODE_W*i +: CODE_W]),
            .tick(tick_o[i])
        );
    end
endmodule

// File: rtl/dvb_bank_chk.sv
module dvb_bank_chk
    import dvb_pkg::*;
#(
    parameter int NUM_OUT = 6
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      commit,
    input logic [NUM_OUT*CODE_W-1:0] shd_codes,
    input logic [NUM_OUT*CODE_W-1:0] act_codes,
    input logic [NUM_OUT-1:0]        tick_o,
    input logic [NUM_OUT-1:0]        err_o
);
    assert_commit_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    assert_hold_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(act_codes));

    assert_commit_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (act_codes == $past(shd_codes)));

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        assert_tick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o[i] |=> !tick_o[i]);

        assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
            err_o[i] |=> err_o[i]);

        assert_no_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (act_codes[CODE_W*i +: CODE_W] != 4'd12) && (act_codes[CODE_W*i +: CODE_W] != 4'd15));
    end
endmodule

bind dvb_bank dvb_bank_chk #(.NUM_OUT(NUM_OUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .commit(commit), .shd_codes(shd_codes),
    .act_codes(act_codes), .tick_o(tick_o), .err_o(err_o)
);

// File: tb/dvb_bank_test.sv
`timescale 1ns/1ps
module dvb_bank_test;
    localparam int NO = 6;
    localparam int SL = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [0:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [NO-1:0] tick_o, err_o;

    int n_chk = 0, n_err = 0, cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dvb_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tick_o(tick_o), .err_o(err_o)
    );

    function automatic int tb_div(int c);
        case (c)
            0: return 2;   1: return 3;   2: return 4;   3: return 6;
            4: return 8;   5: return 12;  6: return 16;  7: return 18;
            8: return 24;  9: return 32;  10: return 36; 11: return 48;
            13: return 72; 14: return 96; default: return 0;
        endcase
    endfunction

    function automatic bit tb_legal(int o, int c);
        logic [15:0] m;
        m = (o == NO-1) ? 16'h677C : 16'h6FFF;
        return m[c] && (tb_div(c) != 0);
    endfunction

    // behavioural reference
    int m_shd[NO], m_act[NO], m_cnt[NO];
    bit m_err[NO];
    bit m_kick;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int o = 0; o < NO; o++) begin
                m_shd[o] = 0; m_act[o] = 0; m_cnt[o] = 0; m_err[o] = 0;
            end
            m_kick = 0;
        end else begin
            bit nk;
            for (int o = 0; o < NO; o++) begin
                if (m_kick) begin
                    m_act[o] = m_shd[o]; m_cnt[o] = 0;
                end else begin
                    m_cnt[o] = (m_cnt[o] == tb_div(m_act[o]) - 1) ? 0 : m_cnt[o] + 1;
                end
            end
            nk = !m_kick && wr_en && (wr_addr == 0) && wr_data[31];
            if (wr_en) begin
                for (int o = 0; o < NO; o++) begin
                    if (o / SL == int'(wr_addr)) begin
                        int c;
                        c = int'((wr_data >> (4 * (o % SL))) & 32'hF);
                        if (tb_legal(o, c)) m_shd[o] = c;
                        else                m_err[o] = 1;
                    end
                end
            end
            m_kick = nk;
        end
    end

    function automatic logic [31:0] exp_word(int a);
        logic [31:0] w;
        w = '0;
        for (int o = 0; o < NO; o++)
            if (o / SL == a) w[4*(o%SL) +: 4] = 4'(m_shd[o]);
        if (a == 0) w[31] = m_kick;
        return w;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h at t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [NO-1:0] et, ee;
            for (int o = 0; o < NO; o++) begin
                et[o] = (m_cnt[o] == tb_div(m_act[o]) - 1);
                ee[o] = m_err[o];
            end
            check(tick_o == et, "R5 R7", "tick vector", int'(tick_o), int'(et));
            check(err_o == ee, "R3 R10", "error flags", int'(err_o), int'(ee));
            check(rd_data == exp_word(int'(rd_addr)), "R9", "readback", int'(rd_data),
                  int'(exp_word(int'(rd_addr))));
        end
    end

    task automatic wr(int a, logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = 1'(a); wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic measure(int o, int exp, string req);
        int n;
        n = 0;
        @(negedge clk);
        while (!tick_o[o]) @(negedge clk);
        @(negedge clk);
        n = 1;
        while (!tick_o[o]) begin
            @(negedge clk);
            n++;
        end
        check(n == exp, req, $sformatf("period of output %0d", o), n, exp);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R8: reset state
        check(tick_o == '0, "R8", "tick after reset", int'(tick_o), 0);
        check(err_o == '0, "R8", "err after reset", int'(err_o), 0);
        check(rd_data == 32'h0, "R8", "word0 after reset", int'(rd_data), 0);
        measure(0, 2, "R8");

        // R4: shadow write alone leaves period unchanged
        wr(0, 32'h0000_3D71);
        measure(0, 2, "R4");
        rd_addr = 1'b0; #1;
        check(rd_data == 32'h0000_3D71, "R9", "word0 shadow", int'(rd_data), 32'h3D71);

        // R5 R6: commit
        wr(0, 32'h8000_3D71);
        rd_addr = 1'b0; #1;
        check(rd_data[31] == 1'b1, "R6", "commit bit pending", int'(rd_data[31]), 1);
        @(posedge clk); #1;
        check(rd_data[31] == 1'b0, "R6", "commit bit cleared", int'(rd_data[31]), 0);
        measure(0, 3, "R7 R1");
        measure(1, 18, "R7 R1");
        measure(2, 72, "R1");
        measure(3, 6, "R1");

        // R2 R3: illegal codes refused
        wr(1, 32'h0000_0029);
        wr(1, 32'h0000_000C);
        rd_addr = 1'b1; #1;
        check(err_o == 6'b110000, "R2 R3", "error flags", int'(err_o), 6'b110000);
        check(rd_data[7:0] == 8'h29, "R3", "word1 shadow kept", int'(rd_data[7:0]), 8'h29);
        wr(0, 32'h8000_3D71);
        measure(4, 32, "R1");
        measure(5, 4, "R3");

        // R10: sticky after legal write
        wr(1, 32'h0000_003A);
        #1;
        check(err_o == 6'b110000, "R10", "sticky flags", int'(err_o), 6'b110000);
        wr(0, 32'h8000_3D71);
        measure(4, 36, "R1");
        measure(5, 6, "R1");

        // R1: full table on output 0
        for (int c = 0; c < 15; c++) begin
            if (c == 12) continue;
            wr(0, 32'h8000_3D70 | 32'(c));
            measure(0, tb_div(c), "R1");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule